// File: doc/BRIEF.md
# Radix-16 Signed-Digit Carry-Free Adder/Subtractor

This combinational block adds a two's complement binary operand to, or subtracts it from, a multi-digit radix-16 signed-digit number. The result is again a radix-16 signed-digit number. Every digit of the signed-digit operand and of the result lies in the maximally redundant set [-15, 15]. No carry travels further than one digit position, so the delay does not depend on the operand length. A typical use is the partial remainder update of a high-radix digit-recurrence divider. There the shifted remainder stays in signed-digit form and a selected divisor multiple is added or subtracted on every step.

Each digit takes five bits. The upper bit is a negabit that weighs -16 when it is low and 0 when it is high. The lower four bits are ordinary posibits of weight 8, 4, 2 and 1. The binary operand has four bits per digit position, and nibble i lines up with digit i. Within each position, a local sum decides whether one unit passes up to the next digit. The digit then absorbs the unit arriving from below. At the lowest position that arriving unit is the subtract control itself, which supplies the +1 of two's complement negation. The top position passes nothing upward, so the caller must keep the true result inside the range of the top digit.

Top module: `sd16_cfadd`

## Requirements
- R1: A digit code c (5 bits: bit 4 the negabit, bits 3:0 the posibits) has value c - 16, so code 16 is zero, code 31 is +15 and code 1 is -15. Code 0 is not a valid operand digit.
- R2: With `sub` = 0, the value of `sd_out` equals the value of `sd_in` plus `bin_in`, where `bin_in` is read as a two's complement number of 4*NDIG bits and each nibble i weighs 16^i.
- R3: With `sub` = 1, the value of `sd_out` equals the value of `sd_in` minus `bin_in`.
- R4: For valid operand digits, every result digit below the top lies in [-15, 15] (its code is never 0). The top digit does too whenever the exact result fits.
- R5: Changing only nibble k of `bin_in` alters no result digit other than digits k and k+1.
- R6: A position below the top passes one unit to the next digit exactly when its digit value plus its (possibly inverted) unsigned nibble is at least 15. That position then keeps the sum minus 16. Example: digit 0 = +15 and all else zero gives digit 0 = -1 (code 15) and digit 1 = +1 (code 17).
- R7: The unit entering the lowest digit equals `sub`. Subtracting zero from zero therefore gives all digits zero (code 16).
- R8: The top nibble of `bin_in` is signed, and the top position passes nothing upward. Example: zero plus 0x8 in the top nibble gives a top digit of -8 (code 8).
- R9: The digit count NDIG is a parameter, and R2 and R3 hold for any NDIG of at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sd_in | input | 5*NDIG | Signed-digit operand, digit i in bits 5i+4:5i |
| bin_in | input | 4*NDIG | Two's complement binary operand, nibble i aligned with digit i |
| sub | input | 1 | 0 adds `bin_in`, 1 subtracts it |
| sd_out | output | 5*NDIG | Signed-digit result, same layout as `sd_in` |

## Verification
Two events can land on one digit in the same evaluation. The first is the unit a position sends upward because its local sum reached 15. The second is the unit it receives from below, which at digit 0 is the negation unit from `sub`. Subtracting small values from a zero operand provokes this: the inverted nibbles are all 15, so every position sends a unit and receives one at once. The result is judged both as a whole value and digit by digit against the expected codes. Separate directed cases isolate each event alone, and the locality case confirms that a changed nibble reaches only its own digit and the next.

// File: rtl/sd16_cfadd.sv
`timescale 1ns/1ps
module sd16_cfadd #(
  parameter int NDIG = 8
) (
  input  logic [5*NDIG-1:0] sd_in,
  input  logic [4*NDIG-1:0] bin_in,
  input  logic              sub,
  output logic [5*NDIG-1:0] sd_out
);
  localparam int BW = 4 * NDIG;

  logic [BW-1:0]   bin_eff;
  logic [NDIG-1:0] xfer;

  assign bin_eff = bin_in ^ {BW{sub}};
  assign xfer[0] = sub;

  for (genvar i = 0; i < NDIG; i++) begin : g_pos
    logic [4:0] wc;
    logic [3:0] yn;
    assign wc = sd_in[5*i +: 5];
    assign yn = bin_eff[4*i +: 4];

    if (i < NDIG - 1) begin : g_mid
      logic [5:0] s6;
      assign s6 = {1'b0, wc[4], 4'b0000} + {2'b00, wc[3:0]} + {2'b00, yn};
      assign xfer[i+1] = (s6 >= 6'd31);
      assign sd_out[5*i +: 5] = 5'(s6 - (xfer[i+1] ? 6'd16 : 6'd0) + {5'b0, xfer[i]});

      always_comb begin
        // R2
        slice_sum_chk: assert (int'(sd_out[5*i +: 5]) + 16 * int'(xfer[i+1]) - int'(xfer[i])
                               == int'(wc) + int'(yn))
          else $error("slice %0d loses value", i);
        // R4
        digit_range_chk: assert (wc == 5'd0 || sd_out[5*i +: 5] != 5'd0)
          else $error("slice %0d digit out of range", i);
        // R6
        xfer_sign_chk: assert (!xfer[i+1] || wc[4])
          else $error("slice %0d transfer from negative digit", i);
      end
    end else begin : g_top
      logic signed [6:0] top_val;
      assign sd_out[5*i +: 5] = wc + {yn[3], yn} + {4'b0000, xfer[i]};
      assign top_val = 7'(signed'({2'b00, wc}) - 7'sd16 + signed'({{3{yn[3]}}, yn})
                          + signed'({6'b0, xfer[i]}));

      always_comb begin
        // R8
        top_sum_chk: assert (top_val < -7'sd15 || top_val > 7'sd15
                             || int'(sd_out[5*i +: 5]) - 16 == int'(top_val))
          else $error("top digit mismatch");
      end
    end
  end
endmodule

// File: tb/sd16_cfadd_test.sv
`timescale 1ns/1ps
module sd16_cfadd_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5*N-1:0] w;
  logic [4*N-1:0] y;
  logic           sub;
  logic [5*N-1:0] s;
  logic [5*NS-1:0] ws, ss;
  logic [4*NS-1:0] ys;
  logic            subs;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  sd16_cfadd #(.NDIG(N)) uut (.sd_in(w), .bin_in(y), .sub(sub), .sd_out(s));
  sd16_cfadd #(.NDIG(NS)) uut_small (.sd_in(ws), .bin_in(ys), .sub(subs), .sd_out(ss));

  function automatic longint sdval(input logic [79:0] v, input int n);
    longint acc = 0;
    for (int i = n - 1; i >= 0; i--) acc = acc * 16 + (longint'(v[5*i +: 5]) - 16);
    return acc;
  endfunction

  function automatic longint binval(input logic [63:0] v, input int n);
    longint b = longint'(v & ((64'd1 << (4*n)) - 64'd1));
    if (v[4*n-1]) b = b - (longint'(1) << (4*n));
    return b;
  endfunction

  function automatic logic [4:0] rnd_code(input int lim);
    return 5'(16 - lim + int'($urandom % (2*lim + 1)));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5*N-1:0] wv, input logic [4*N-1:0] yv, input logic sv);
    @(negedge clk);
    w = wv; y = yv; sub = sv;
    @(posedge clk);
    #1;
  endtask

  task automatic check_range(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++) if (s[5*i +: 5] == 5'd0) bad++;
    check(req, bad, 0);
  endtask

  function automatic logic [5*N-1:0] zeros();
    logic [5*N-1:0] z;
    for (int i = 0; i < N; i++) z[5*i +: 5] = 5'd16;
    return z;
  endfunction

  task automatic t_zero();
    apply(zeros(), '0, 1'b0);
    check("R1 zero digits stay code 16", longint'(s), longint'(zeros()));
    check("R2 zero sum value", sdval(s, N), 0);
  endtask

  task automatic t_transfer();
    logic [5*N-1:0] wv = zeros();
    logic [5*N-1:0] ev = zeros();
    wv[4:0] = 5'd31;
    ev[4:0] = 5'd15; ev[9:5] = 5'd17;
    apply(wv, '0, 1'b0);
    check("R6 digit +15 sends unit up", longint'(s), longint'(ev));
    wv[4:0] = 5'd30;
    ev = zeros(); ev[4:0] = 5'd30;
    apply(wv, '0, 1'b0);
    check("R6 digit +14 keeps its unit", longint'(s), longint'(ev));
  endtask

  task automatic t_sub_unit();
    logic [5*N-1:0] ev = zeros();
    apply(zeros(), '0, 1'b1);
    check("R7 zero minus zero all code 16", longint'(s), longint'(zeros()));
    ev[4:0] = 5'd31; ev[9:5] = 5'd15;
    apply(zeros(), 32'd1, 1'b1);
    check("R7 zero minus one digit pattern", longint'(s), longint'(ev));
    check("R3 zero minus one value", sdval(s, N), -1);
  endtask

  task automatic t_top();
    logic [5*N-1:0] ev = zeros();
    ev[5*(N-1) +: 5] = 5'd8;
    apply(zeros(), 32'h8000_0000, 1'b0);
    check("R8 signed top nibble", longint'(s), longint'(ev));
    check("R8 top value", sdval(s, N), -(longint'(8) << (4*(N-1))));
  endtask

  task automatic t_locality();
    logic [5*N-1:0] wv, s0;
    logic [4*N-1:0] yv;
    int diff;
    for (int k = 0; k < N - 1; k++) begin
      for (int i = 0; i < N; i++) wv[5*i +: 5] = (i == N-1) ? rnd_code(7) : rnd_code(15);
      yv = $urandom;
      apply(wv, yv, 1'b0);
      s0 = s;
      yv[4*k +: 4] = yv[4*k +: 4] ^ 4'(1 + $urandom % 15);
      apply(wv, yv, 1'b0);
      diff = 0;
      for (int i = 0; i < N; i++)
        if (i != k && i != k + 1 && s[5*i +: 5] != s0[5*i +: 5]) diff++;
      check("R5 change stays local", diff, 0);
      check("R2 value after nibble change", sdval(s, N), sdval(wv, N) + binval(yv, N));
    end
  endtask

  task automatic t_extremes();
    logic [5*N-1:0] wp, wn;
    for (int i = 0; i < N; i++) begin
      wp[5*i +: 5] = (i == N-1) ? 5'd23 : 5'd31;
      wn[5*i +: 5] = (i == N-1) ? 5'd9 : 5'd1;
    end
    apply(wp, 32'h7FFF_FFFF, 1'b0);
    check("R2 max digits plus max", sdval(s, N), sdval(wp, N) + 64'sh7FFF_FFFF);
    check_range("R4 max plus max");
    apply(wn, 32'h8000_0000, 1'b0);
    check("R2 min digits plus min", sdval(s, N), sdval(wn, N) - 64'sh8000_0000);
    check_range("R4 min plus min");
    apply(wp, 32'h8000_0000, 1'b1);
    check("R3 max minus min", sdval(s, N), sdval(wp, N) + 64'sh8000_0000);
    check_range("R4 max minus min");
    apply(wn, 32'h7FFF_FFFF, 1'b1);
    check("R3 min minus max", sdval(s, N), sdval(wn, N) - 64'sh7FFF_FFFF);
    check_range("R4 min minus max");
  endtask

  task automatic t_random();
    logic [5*N-1:0] wv;
    logic [4*N-1:0] yv;
    logic sv;
    longint exp;
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < N; i++) wv[5*i +: 5] = (i == N-1) ? rnd_code(7) : rnd_code(15);
      yv = $urandom;
      sv = 1'($urandom);
      apply(wv, yv, sv);
      exp = sv ? sdval(wv, N) - binval(yv, N) : sdval(wv, N) + binval(yv, N);
      check(sv ? "R3 random difference" : "R2 random sum", sdval(s, N), exp);
      check_range("R4 random digits");
    end
  endtask

  task automatic t_small();
    longint exp;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      for (int i = 0; i < NS; i++) ws[5*i +: 5] = (i == NS-1) ? rnd_code(7) : rnd_code(15);
      ys = 12'($urandom);
      subs = 1'($urandom);
      @(posedge clk);
      #1;
      exp = subs ? sdval(ws, NS) - binval(ys, NS) : sdval(ws, NS) + binval(ys, NS);
      check("R9 three-digit instance", sdval(ss, NS), exp);
    end
  endtask

  initial begin
    w = '0; y = '0; sub = 1'b0;
    ws = '0; ys = '0; subs = 1'b0;
    t_zero();
    t_transfer();
    t_sub_unit();
    t_top();
    t_locality();
    t_extremes();
    t_random();
    t_small();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule